// File: doc/BRIEF.md
# Write Command Clock-Count Guard

This block sits beside the command decoder of a small serial non-volatile memory and decides whether a write-class command may start. From the serial clock edge that carries the start bit until chip select falls, it counts serial clock rising edges. When chip select falls, it compares that count with the exact frame length that the decoded command needs.

A data write or a fill-all write permits only an exact match. The same holds for a single-word erase or an erase-all. Any shortfall or excess gives a cancel pulse instead. A frame corrupted by a noise pulse or by a doubly counted clock therefore cannot become a write. A typical case is a disable command that gains one extra edge and decodes as an erase of word 0.

The required lengths follow from the address width. A command without data needs 3 plus the address width. A command that carries a data word needs the word width more. Reads and write-enable changes pass through without either pulse. A cancelled command has no further effect, so the memory and the enable latch stay untouched.

Top module: `wr_clock_guard`

## Requirements
- R1: A WRITE (op=01) or WRAL (op=00, ext=01) frame of exactly AW+3+DW counted edges (25 with defaults) gives `permit` high for exactly one cycle, with `cancel` low.
- R2: An ERASE (op=11) or ERAL (op=00, ext=10) frame of exactly AW+3 counted edges (9 with defaults) gives a one-cycle `permit` pulse.
- R3: A write-class frame with more counted edges than its required length gives a one-cycle `cancel` pulse and no `permit`. This includes a disable frame that gains one noise edge and decodes as ERASE with 10 edges.
- R4: A write-class frame with fewer counted edges than required gives a one-cycle `cancel` pulse and no `permit`.
- R5: READ (op=10), EWEN (op=00, ext=11) and EWDS (op=00, ext=00) frames never produce `permit` or `cancel`, whatever their length.
- R6: Edges strobed while `start_seen` is low before the start bit are not counted. The start-bit edge counts as edge 1.
- R7: The counter saturates. A frame longer than the required length by any amount, including exactly a multiple of the counter range, is cancelled.
- R8: `permit` and `cancel` are never high together. Either one rises only in the cycle after the clock edge at which `sel` is first seen low. Edges strobed while `sel` is low are ignored.
- R9: A frame in which `start_seen` never coincides with an edge produces neither pulse.
- R10: During and right after reset, `permit` and `cancel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select level, already synchronised |
| sk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| start_seen | input | 1 | High together with the strobe that carries the start bit |
| op | input | 2 | Decoded opcode, stable when `sel` falls |
| ext | input | 2 | Opcode extension (top two address bits), stable when `sel` falls |
| permit | output | 1 | One-cycle pulse: write-class command may start |
| cancel | output | 1 | One-cycle pulse: write-class command rejected |

## Verification
The assertions assume that `op` and `ext` are already valid in the cycle when `sel` is seen low. They also assume that `sk_rise` is a single-cycle strobe that never arrives in two back-to-back cycles. The stimulus meets both assumptions: it sets the opcode before raising `sel` and holds it until well after deselect. Every edge strobe is followed by an idle cycle. Frames are always separated by several deselected cycles, so each outcome pulse is tied to one frame.

// File: rtl/wr_clock_guard.sv
module wr_clock_guard #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sk_rise,
  input  logic       start_seen,
  input  logic [1:0] op,
  input  logic [1:0] ext,
  output logic       permit,
  output logic       cancel
);
  localparam int NEED_SHORT = 3 + AW;
  localparam int NEED_LONG  = NEED_SHORT + DW;
  localparam int CW         = $clog2(NEED_LONG + 2);
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [CW-1:0] SHORTC = CW'(NEED_SHORT);
  localparam logic [CW-1:0] LONGC  = CW'(NEED_LONG);

  logic          sel_q;
  logic          active;
  logic [CW-1:0] cnt;

  wire cs_fall  = sel_q & ~sel;
  wire has_data = (op == 2'b01) | ((op == 2'b00) & (ext == 2'b01));
  wire no_data  = (op == 2'b11) | ((op == 2'b00) & (ext == 2'b10));
  wire wclass   = has_data | no_data;
  wire [CW-1:0] need = has_data ? LONGC : SHORTC;
  wire exact    = (cnt == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      permit <= 1'b0;
      cancel <= 1'b0;
    end else begin
      sel_q  <= sel;
      permit <= 1'b0;
      cancel <= 1'b0;
      if (cs_fall) begin
        permit <= active & wclass & exact;
        cancel <= active & wclass & ~exact;
        active <= 1'b0;
        cnt    <= '0;
      end else if (sel && sk_rise) begin
        if (!active) begin
          if (start_seen) begin
            active <= 1'b1;
            cnt    <= CW'(1);
          end
        end else if (cnt != CMAX) begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

module wr_clock_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic [1:0] op,
  input logic [1:0] ext,
  input logic       permit,
  input logic       cancel
);
  logic wc_in;
  assign wc_in = (op == 2'b01) || (op == 2'b11) ||
                 ((op == 2'b00) && ((ext == 2'b01) || (ext == 2'b10)));

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && cancel)); // R8
  AST_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (permit || cancel) |-> !$past(sel)); // R8
  AST_WRITES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (permit || cancel) |-> $past(wc_in)); // R5
  AST_PERMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    permit |=> !permit); // R1
  AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !cancel); // R3
endmodule

bind wr_clock_guard wr_clock_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .op(op), .ext(ext),
  .permit(permit), .cancel(cancel)
);

// File: tb/wr_clock_guard_tb.sv
`timescale 1ns/1ps
module wr_clock_guard_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int SHORT_N = AW + 3;
  localparam int LONG_N  = AW + 3 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sk_rise = 1'b0, start_seen = 1'b0;
  logic [1:0] op = 2'b00, ext = 2'b00;
  logic permit, cancel;

  int checks = 0;
  int errors = 0;
  bit seen_p, seen_c;
  bit done = 0;

  always #2.5 clk = ~clk;

  wr_clock_guard #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sk_rise(sk_rise),
    .start_seen(start_seen), .op(op), .ext(ext),
    .permit(permit), .cancel(cancel)
  );

  // behavioural reference, unbounded count
  int  m_cnt = 0;
  bit  m_act = 0, m_selq = 0, exp_p = 0, exp_c = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_selq = 0; exp_p = 0; exp_c = 0;
    end else begin
      bit dat, wc;
      int need;
      exp_p = 0; exp_c = 0;
      dat  = (op == 2'b01) || (op == 2'b00 && ext == 2'b01);
      wc   = dat || (op == 2'b11) || (op == 2'b00 && ext == 2'b10);
      need = dat ? LONG_N : SHORT_N;
      if (m_selq && !sel) begin
        if (m_act && wc) begin
          exp_p = (m_cnt == need);
          exp_c = (m_cnt != need);
        end
        m_act = 0; m_cnt = 0;
      end else if (sel && sk_rise) begin
        if (!m_act && start_seen) begin m_act = 1; m_cnt = 1; end
        else if (m_act) m_cnt++;
      end
      m_selq = sel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (permit !== exp_p || cancel !== exp_c) begin
        errors++;
        $display("FAIL R8 model compare: permit/cancel=%b%b expected %b%b", permit, cancel, exp_p, exp_c);
      end
      if (permit) seen_p = 1;
      if (cancel) seen_c = 1;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic strobe(input bit st);
    sk_rise = 1; start_seen = st; tick();
    sk_rise = 0; start_seen = 0; tick();
  endtask

  task automatic frame(input string tag, input logic [1:0] o, input logic [1:0] e,
                       input int dummy, input int n, input bit with_start,
                       input bit want_p, input bit want_c);
    op = o; ext = e; seen_p = 0; seen_c = 0;
    tick();
    sel = 1; tick();
    for (int i = 0; i < dummy; i++) strobe(0);
    if (n > 0) strobe(with_start);
    for (int i = 1; i < n; i++) strobe(0);
    sel = 0;
    for (int i = 0; i < 4; i++) tick();
    checks++;
    if (seen_p !== want_p || seen_c !== want_c) begin
      errors++;
      $display("FAIL %s: permit/cancel seen=%b%b expected %b%b", tag, seen_p, seen_c, want_p, want_c);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    checks++;
    if (permit !== 1'b0 || cancel !== 1'b0) begin // R10
      errors++;
      $display("FAIL R10 reset: permit/cancel=%b%b expected 00", permit, cancel);
    end
    rst_n = 1; tick(); tick();
    checks++;
    if (permit !== 1'b0 || cancel !== 1'b0) begin
      errors++;
      $display("FAIL R10 after reset: permit/cancel=%b%b expected 00", permit, cancel);
    end

    frame("R1 write exact",  2'b01, 2'b10, 0, LONG_N, 1, 1, 0);
    frame("R1 wral exact",   2'b00, 2'b01, 0, LONG_N, 1, 1, 0);
    frame("R2 erase exact",  2'b11, 2'b00, 0, SHORT_N, 1, 1, 0);
    frame("R2 eral exact",   2'b00, 2'b10, 0, SHORT_N, 1, 1, 0);
    frame("R3 write long",   2'b01, 2'b00, 0, LONG_N + 1, 1, 0, 1);
    frame("R3 disable+noise as erase", 2'b11, 2'b00, 0, SHORT_N + 1, 1, 0, 1);
    frame("R3 eral long",    2'b00, 2'b10, 0, SHORT_N + 1, 1, 0, 1);
    frame("R4 write short",  2'b01, 2'b11, 0, LONG_N - 1, 1, 0, 1);
    frame("R4 erase short",  2'b11, 2'b01, 0, SHORT_N - 1, 1, 0, 1);
    frame("R4 wral short",   2'b00, 2'b01, 0, SHORT_N, 1, 0, 1);
    frame("R5 read",         2'b10, 2'b00, 0, LONG_N, 1, 0, 0);
    frame("R5 enable",       2'b00, 2'b11, 0, SHORT_N, 1, 0, 0);
    frame("R5 disable long", 2'b00, 2'b00, 0, SHORT_N + 1, 1, 0, 0);
    frame("R6 dummies erase", 2'b11, 2'b10, 5, SHORT_N, 1, 1, 0);
    frame("R6 dummies write", 2'b01, 2'b01, 7, LONG_N, 1, 1, 0);
    frame("R7 erase +32",    2'b11, 2'b00, 0, SHORT_N + 32, 1, 0, 1);
    frame("R7 write +32",    2'b01, 2'b00, 0, LONG_N + 32, 1, 0, 1);
    frame("R7 eral 200",     2'b00, 2'b10, 0, 200, 1, 0, 1);
    frame("R9 no start",     2'b01, 2'b00, 0, LONG_N, 0, 0, 0);
    // R8: strobes during standby are ignored
    for (int i = 0; i < 6; i++) begin
      sk_rise = 1; start_seen = 1; tick();
      sk_rise = 0; start_seen = 0; tick();
    end
    frame("R8 standby strobes ignored", 2'b11, 2'b11, 0, SHORT_N, 1, 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule